// File: doc/BRIEF.md
# DRAM Bank Subarray Row-Buffer Model

This block is a synthesizable behavioural model of one DRAM bank that is split into several subarrays. Each subarray keeps its own small row array and its own row buffer, which stands in for the sense amplifiers. A command port takes activate, precharge, column read, column write and an in-subarray row clone. A second port gives another bank column-wide access to the open row buffer, so a copy between banks never has to leave the memory. Voltages, refresh and real timing are not modelled. Sensing is a fixed delay of `TSENSE` cycles.

Each subarray is in one of three states: equalized (no wordline raised and no valid buffer), sensing (a row is open and the buffer is settling), or stable (the buffer holds the open row). A clone command raises a second wordline onto a stable buffer without a precharge in between. The stable buffer then overwrites the new row, and that row becomes the open one. This copies a whole row inside a subarray in a single command. Only one subarray of the bank may have a row open at a time.

The default geometry is small: 2 subarrays, 8 rows, 4 columns and 32-bit columns. A real part has 512 rows per subarray and 64-byte columns, and both can be reached by changing the parameters.

Top module: `dram_bank_model`

## Requirements
- R1: After reset every subarray is equalized, `rd_valid`, `cmd_err`, `xfer_rvalid` and `xfer_err` are low, `cmd_ready` is high and every stored cell is zero.
- R2: An activate (op 1) to an equalized subarray is accepted when no other subarray is open. After `TSENSE` clock edges the row is readable. A read (op 3) accepted at one edge raises `rd_valid` with the column data after that edge. Activating never changes the row's cells.
- R3: A read to a subarray that is still sensing lowers `cmd_ready` in the same cycle. It is not accepted, and it produces neither `rd_valid` nor `cmd_err`.
- R4: A write (op 4) to a stable subarray updates the addressed column in both the row buffer and the open row's cells, so the data survives a precharge and a re-activate.
- R5: A precharge (op 2) returns the subarray to equalized. A read or write to an equalized subarray raises `cmd_err` one cycle later and has no effect.
- R6: An activate to a subarray that already has a row open (sensing or stable) raises `cmd_err`, and the row that was open stays open.
- R7: An activate to one subarray while a different subarray has a row open raises `cmd_err` and opens nothing.
- R8: A clone (op 5) to a stable subarray with destination row D copies the whole row buffer into row D, and D becomes the open row. Later writes go to D, and the former source row keeps its contents.
- R9: A clone to an equalized or still-sensing subarray raises `cmd_err` and writes no row.
- R10: The transfer port reads or writes one column of the stable open buffer. A write also updates the open row's cells, and read data appears one cycle after the request with `xfer_rvalid`. A request raises `xfer_err` one cycle later, and is dropped, in either of two cases: no subarray is stable, or the command port carries a write, clone or precharge in the same cycle.
- R11: At most one subarray of the bank has a row open in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 3 | 0 nop, 1 activate, 2 precharge, 3 read, 4 write, 5 clone |
| cmd_sub | input | SUB_W | Target subarray |
| cmd_row | input | ROW_W | Row for activate or clone destination |
| cmd_col | input | COL_IW | Column for read or write |
| cmd_wdata | input | COL_W | Write data |
| cmd_ready | output | 1 | Low while a read waits on sensing |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | COL_W | Read data |
| cmd_err | output | 1 | Previous accepted command was illegal |
| xfer_en | input | 1 | Transfer port request |
| xfer_we | input | 1 | Transfer is a write |
| xfer_col | input | COL_IW | Transfer column |
| xfer_wdata | input | COL_W | Transfer write data |
| xfer_rvalid | output | 1 | Transfer read data valid |
| xfer_rdata | output | COL_W | Transfer read data |
| xfer_err | output | 1 | Previous transfer request was dropped |

## Verification
The assertions check the following on every cycle:
- no more than one subarray is open;
- an equalized subarray never goes straight to stable;
- read data only follows a read command;
- a stalled read leaves no trace;
- data and error flags never appear together on the same port.

Only the scenarios show data behaviour:
- cells are restored unchanged by an activate;
- a clone copies the whole buffer into the destination and retargets later writes;
- a rejected clone leaves its destination untouched;
- transfer-port writes land in the stored row.

// File: rtl/dram_sa_pkg.sv
package dram_sa_pkg;

   typedef enum logic [2:0] {
      OP_NOP   = 3'd0,
      OP_ACT   = 3'd1,
      OP_PRE   = 3'd2,
      OP_RD    = 3'd3,
      OP_WR    = 3'd4,
      OP_CLONE = 3'd5
   } bank_op_e;

   typedef enum logic [1:0] {
      SA_IDLE   = 2'd0,
      SA_SENSE  = 2'd1,
      SA_STABLE = 2'd2
   } sa_state_e;

endpackage

// File: rtl/sa_sense_fsm.sv
module sa_sense_fsm
   import dram_sa_pkg::*;
#(
   parameter int TSENSE = 3
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      open_req,
   input  logic      close_req,
   output sa_state_e state
);

   if (TSENSE < 1) begin : g_bad_tsense
      $error("TSENSE must be at least 1");
   end

   if (TSENSE == 1) begin : g_direct
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            state <= SA_IDLE;
         end else if (close_req) begin
            state <= SA_IDLE;
         end else begin
            case (state)
               SA_IDLE:  if (open_req) state <= SA_SENSE;
               SA_SENSE: state <= SA_STABLE;
               default:  state <= state;
            endcase
         end
      end
   end else begin : g_count
      localparam int CNT_W = $clog2(TSENSE);
      logic [CNT_W-1:0] cnt;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            state <= SA_IDLE;
            cnt   <= '0;
         end else if (close_req) begin
            state <= SA_IDLE;
            cnt   <= '0;
         end else begin
            case (state)
               SA_IDLE: begin
                  if (open_req) begin
                     state <= SA_SENSE;
                     cnt   <= CNT_W'(TSENSE - 1);
                  end
               end
               SA_SENSE: begin
                  if (cnt == '0) state <= SA_STABLE;
                  else           cnt   <= cnt - 1'b1;
               end
               default: state <= state;
            endcase
         end
      end
   end

   // R2
   no_skip_sense_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SA_IDLE) |=> (state != SA_STABLE));

   // R6
   stable_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SA_STABLE && !close_req) |=> (state == SA_STABLE));

endmodule

// File: rtl/sa_row_store.sv
module sa_row_store #(
   parameter int ROWS  = 8,
   parameter int COLS  = 4,
   parameter int COL_W = 32,
   localparam int ROW_W  = (ROWS > 1) ? $clog2(ROWS) : 1,
   localparam int COL_IW = (COLS > 1) ? $clog2(COLS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_en,
   input  logic [ROW_W-1:0]  load_row,
   input  logic              clone_en,
   input  logic [ROW_W-1:0]  clone_row,
   input  logic              wr_en,
   input  logic [ROW_W-1:0]  wr_row,
   input  logic [COL_IW-1:0] wr_col,
   input  logic [COL_W-1:0]  wr_data,
   input  logic [COL_IW-1:0] rd_col_a,
   input  logic [COL_IW-1:0] rd_col_b,
   output logic [COL_W-1:0]  rd_data_a,
   output logic [COL_W-1:0]  rd_data_b
);

   logic [COL_W-1:0] cells  [ROWS][COLS];
   logic [COL_W-1:0] sense_q [COLS];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++)
               cells[r][c] <= '0;
         for (int c = 0; c < COLS; c++)
            sense_q[c] <= '0;
      end else begin
         if (load_en) begin
            for (int c = 0; c < COLS; c++)
               sense_q[c] <= cells[load_row][c];
         end
         if (clone_en) begin
            for (int c = 0; c < COLS; c++)
               cells[clone_row][c] <= sense_q[c];
         end
         if (wr_en) begin
            sense_q[wr_col]       <= wr_data;
            cells[wr_row][wr_col] <= wr_data;
         end
      end
   end

   assign rd_data_a = sense_q[rd_col_a];
   assign rd_data_b = sense_q[rd_col_b];

   // R8
   clone_write_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(clone_en && wr_en));

endmodule

// File: rtl/dram_bank_model.sv
module dram_bank_model
   import dram_sa_pkg::*;
#(
   parameter int NUM_SUB = 2,
   parameter int ROWS    = 8,
   parameter int COLS    = 4,
   parameter int COL_W   = 32,
   parameter int TSENSE  = 3,
   localparam int SUB_W  = (NUM_SUB > 1) ? $clog2(NUM_SUB) : 1,
   localparam int ROW_W  = (ROWS > 1) ? $clog2(ROWS) : 1,
   localparam int COL_IW = (COLS > 1) ? $clog2(COLS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [2:0]        cmd_op,
   input  logic [SUB_W-1:0]  cmd_sub,
   input  logic [ROW_W-1:0]  cmd_row,
   input  logic [COL_IW-1:0] cmd_col,
   input  logic [COL_W-1:0]  cmd_wdata,
   output logic              cmd_ready,
   output logic              rd_valid,
   output logic [COL_W-1:0]  rd_data,
   output logic              cmd_err,
   input  logic              xfer_en,
   input  logic              xfer_we,
   input  logic [COL_IW-1:0] xfer_col,
   input  logic [COL_W-1:0]  xfer_wdata,
   output logic              xfer_rvalid,
   output logic [COL_W-1:0]  xfer_rdata,
   output logic              xfer_err
);

   if (NUM_SUB < 1 || ROWS < 2 || COLS < 1 || COL_W < 1) begin : g_bad_geom
      $error("dram_bank_model: illegal geometry parameters");
   end

   bank_op_e  op;
   sa_state_e st [NUM_SUB];
   sa_state_e tgt_state;
   logic [ROW_W-1:0] open_row [NUM_SUB];
   logic [COL_W-1:0] buf_a [NUM_SUB];
   logic [COL_W-1:0] buf_b [NUM_SUB];
   logic [NUM_SUB-1:0] open_vec, stable_vec, tgt_hit;
   logic sub_ok, other_open, stall, accept;
   logic act_ok, pre_ok, rd_ok, wr_ok, clone_ok, bad;
   logic stable_any, cmd_blocks_xfer, xfer_ok, xfer_wr;
   logic [SUB_W-1:0] xsub;

   assign op = bank_op_e'(cmd_op);

   always_comb begin
      sub_ok    = (32'(cmd_sub) < NUM_SUB);
      tgt_state = SA_IDLE;
      xsub      = '0;
      for (int s = 0; s < NUM_SUB; s++) begin
         open_vec[s]   = (st[s] != SA_IDLE);
         stable_vec[s] = (st[s] == SA_STABLE);
         tgt_hit[s]    = sub_ok && (cmd_sub == SUB_W'(s));
         if (tgt_hit[s]) tgt_state = st[s];
         if (stable_vec[s]) xsub = SUB_W'(s);
      end
      other_open = |(open_vec & ~tgt_hit);
      stable_any = |stable_vec;
   end

   assign stall     = cmd_valid && (op == OP_RD) && sub_ok && (tgt_state == SA_SENSE);
   assign cmd_ready = !stall;
   assign accept    = cmd_valid && !stall;

   assign act_ok   = accept && (op == OP_ACT) && sub_ok &&
                     (tgt_state == SA_IDLE) && !other_open;
   assign pre_ok   = accept && (op == OP_PRE) && sub_ok;
   assign rd_ok    = accept && (op == OP_RD) && sub_ok && (tgt_state == SA_STABLE);
   assign wr_ok    = accept && (op == OP_WR) && sub_ok && (tgt_state == SA_STABLE);
   assign clone_ok = accept && (op == OP_CLONE) && sub_ok && (tgt_state == SA_STABLE);
   assign bad      = accept && (op != OP_NOP) &&
                     !(act_ok || pre_ok || rd_ok || wr_ok || clone_ok);

   assign cmd_blocks_xfer = cmd_valid &&
                            (op == OP_WR || op == OP_CLONE || op == OP_PRE);
   assign xfer_ok = xfer_en && stable_any && !cmd_blocks_xfer;
   assign xfer_wr = xfer_ok && xfer_we;

   for (genvar s = 0; s < NUM_SUB; s++) begin : g_sub
      logic              w_en;
      logic [COL_IW-1:0] w_col;
      logic [COL_W-1:0]  w_data;

      assign w_en   = (wr_ok && tgt_hit[s]) || (xfer_wr && (xsub == SUB_W'(s)));
      assign w_col  = wr_ok ? cmd_col   : xfer_col;
      assign w_data = wr_ok ? cmd_wdata : xfer_wdata;

      sa_sense_fsm #(.TSENSE(TSENSE)) u_fsm (
         .clk       (clk),
         .rst_n     (rst_n),
         .open_req  (act_ok && tgt_hit[s]),
         .close_req (pre_ok && tgt_hit[s]),
         .state     (st[s])
      );

      always_ff @(posedge clk) begin
         if (!rst_n)
            open_row[s] <= '0;
         else if ((act_ok || clone_ok) && tgt_hit[s])
            open_row[s] <= cmd_row;
      end

      sa_row_store #(.ROWS(ROWS), .COLS(COLS), .COL_W(COL_W)) u_store (
         .clk       (clk),
         .rst_n     (rst_n),
         .load_en   (act_ok && tgt_hit[s]),
         .load_row  (cmd_row),
         .clone_en  (clone_ok && tgt_hit[s]),
         .clone_row (cmd_row),
         .wr_en     (w_en),
         .wr_row    (open_row[s]),
         .wr_col    (w_col),
         .wr_data   (w_data),
         .rd_col_a  (cmd_col),
         .rd_col_b  (xfer_col),
         .rd_data_a (buf_a[s]),
         .rd_data_b (buf_b[s])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_valid    <= 1'b0;
         rd_data     <= '0;
         cmd_err     <= 1'b0;
         xfer_rvalid <= 1'b0;
         xfer_rdata  <= '0;
         xfer_err    <= 1'b0;
      end else begin
         rd_valid    <= rd_ok;
         cmd_err     <= bad;
         xfer_rvalid <= xfer_ok && !xfer_we;
         xfer_err    <= xfer_en && !xfer_ok;
         if (rd_ok) rd_data <= buf_a[cmd_sub];
         if (xfer_ok && !xfer_we) xfer_rdata <= buf_b[xsub];
      end
   end

   // R11
   single_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(open_vec) <= 1);

   // R2
   rd_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $past(cmd_valid && cmd_op == 3'd3));

   // R3
   stall_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_ready |=> (!rd_valid && !cmd_err));

   // R5
   rd_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_valid && cmd_err));

   // R10
   xfer_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(xfer_rvalid && xfer_err));

endmodule

// File: tb/dram_bank_model_test.sv
module dram_bank_model_test;

   localparam int TS = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [2:0]  cmd_op = '0;
   logic [0:0]  cmd_sub = '0;
   logic [2:0]  cmd_row = '0;
   logic [1:0]  cmd_col = '0;
   logic [31:0] cmd_wdata = '0;
   logic        cmd_ready, rd_valid, cmd_err;
   logic [31:0] rd_data;
   logic        xfer_en = 1'b0, xfer_we = 1'b0;
   logic [1:0]  xfer_col = '0;
   logic [31:0] xfer_wdata = '0;
   logic        xfer_rvalid, xfer_err;
   logic [31:0] xfer_rdata;

   int checks = 0;
   int errors = 0;
   logic [31:0] expq [$];
   logic [31:0] mdl [2][8][4];

   always #5 clk = ~clk;

   dram_bank_model #(.NUM_SUB(2), .ROWS(8), .COLS(4), .COL_W(32), .TSENSE(TS)) uut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_sub(cmd_sub), .cmd_row(cmd_row), .cmd_col(cmd_col), .cmd_wdata(cmd_wdata),
      .cmd_ready(cmd_ready), .rd_valid(rd_valid), .rd_data(rd_data), .cmd_err(cmd_err),
      .xfer_en(xfer_en), .xfer_we(xfer_we), .xfer_col(xfer_col), .xfer_wdata(xfer_wdata),
      .xfer_rvalid(xfer_rvalid), .xfer_rdata(xfer_rdata), .xfer_err(xfer_err)
   );

   task automatic check(input bit ok, input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // monitor: pops expected read data as the design returns it
   always @(negedge clk) begin
      if (rst_n && rd_valid) begin
         if (expq.size() == 0) begin
            check(1'b0, "R2 unexpected rd_valid", rd_data, 32'hx);
         end else begin
            logic [31:0] e;
            e = expq.pop_front();
            check(rd_data === e, "R2 read data", rd_data, e);
         end
      end
   end

   // drive one command; returns ready seen in the drive cycle and err after the edge
   task automatic issue(input logic [2:0] op, input logic s, input logic [2:0] r,
                        input logic [1:0] c, input logic [31:0] d,
                        output logic rdy, output logic err);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = op; cmd_sub = s; cmd_row = r; cmd_col = c; cmd_wdata = d;
      #1 rdy = cmd_ready;
      @(posedge clk); #1 cmd_valid = 1'b0;
      @(negedge clk);
      err = cmd_err;
   endtask

   task automatic do_cmd(input logic [2:0] op, input logic s, input logic [2:0] r,
                         input logic [1:0] c, input logic [31:0] d,
                         input logic exp_err, input string tag);
      logic rdy, err;
      issue(op, s, r, c, d, rdy, err);
      check(err === exp_err, tag, {31'd0, err}, {31'd0, exp_err});
   endtask

   task automatic do_rd(input logic s, input logic [1:0] c, input logic [31:0] exp,
                        input string tag);
      logic rdy, err;
      expq.push_back(exp);
      issue(3'd3, s, 3'd0, c, 32'd0, rdy, err);
      check(err === 1'b0, tag, {31'd0, err}, 32'd0);
   endtask

   task automatic settle();
      repeat (TS + 1) @(posedge clk);
   endtask

   task automatic xfer(input logic we, input logic [1:0] c, input logic [31:0] d,
                       output logic rv, output logic [31:0] rdat, output logic xe);
      @(negedge clk);
      xfer_en = 1'b1; xfer_we = we; xfer_col = c; xfer_wdata = d;
      @(posedge clk); #1 xfer_en = 1'b0;
      @(negedge clk);
      rv = xfer_rvalid; rdat = xfer_rdata; xe = xfer_err;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      check(1'b0, "watchdog expired", 32'd0, 32'd1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic rdy, err, rv, xe;
      logic [31:0] rdat;
      for (int s = 0; s < 2; s++)
         for (int r = 0; r < 8; r++)
            for (int c = 0; c < 4; c++)
               mdl[s][r][c] = '0;

      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(rd_valid === 1'b0 && cmd_err === 1'b0, "R1 outputs low", {30'd0, rd_valid, cmd_err}, 32'd0);
      check(cmd_ready === 1'b1, "R1 ready high", {31'd0, cmd_ready}, 32'd1);
      check(xfer_rvalid === 1'b0 && xfer_err === 1'b0, "R1 xfer low", {30'd0, xfer_rvalid, xfer_err}, 32'd0);
      do_cmd(3'd3, 1'b0, 3'd0, 2'd0, 32'd0, 1'b1, "R1 read while equalized errs");

      // R2 activate then R3 stall while sensing
      do_cmd(3'd1, 1'b0, 3'd2, 2'd0, 32'd0, 1'b0, "R2 activate accepted");
      issue(3'd3, 1'b0, 3'd0, 2'd1, 32'd0, rdy, err);
      check(rdy === 1'b0, "R3 ready low during sensing", {31'd0, rdy}, 32'd0);
      check(err === 1'b0 && rd_valid === 1'b0, "R3 stalled read silent", {30'd0, err, rd_valid}, 32'd0);
      settle();
      do_rd(1'b0, 2'd1, 32'd0, "R1 cells reset to zero");

      // R4 writes to open row
      for (int c = 0; c < 4; c++) begin
         do_cmd(3'd4, 1'b0, 3'd0, 2'(c), 32'hA0 + 32'(c), 1'b0, "R4 write accepted");
         mdl[0][2][c] = 32'hA0 + 32'(c);
      end
      do_rd(1'b0, 2'd2, mdl[0][2][2], "R4 read after write");

      // R6 activate on open subarray
      do_cmd(3'd1, 1'b0, 3'd5, 2'd0, 32'd0, 1'b1, "R6 re-activate errs");
      do_rd(1'b0, 2'd0, mdl[0][2][0], "R6 open row kept");
      // R7 activate other subarray
      do_cmd(3'd1, 1'b1, 3'd1, 2'd0, 32'd0, 1'b1, "R7 cross-subarray activate errs");
      do_cmd(3'd3, 1'b1, 3'd0, 2'd0, 32'd0, 1'b1, "R7 other subarray stayed closed");

      // R8 clone row 2 -> row 5, then write lands in row 5
      do_cmd(3'd5, 1'b0, 3'd5, 2'd0, 32'd0, 1'b0, "R8 clone accepted");
      for (int c = 0; c < 4; c++) mdl[0][5][c] = mdl[0][2][c];
      do_cmd(3'd4, 1'b0, 3'd0, 2'd3, 32'h55, 1'b0, "R8 write after clone");
      mdl[0][5][3] = 32'h55;
      do_cmd(3'd2, 1'b0, 3'd0, 2'd0, 32'd0, 1'b0, "R5 precharge accepted");
      do_cmd(3'd1, 1'b0, 3'd2, 2'd0, 32'd0, 1'b0, "R2 reopen source");
      settle();
      do_rd(1'b0, 2'd3, mdl[0][2][3], "R8 source row unchanged");
      do_cmd(3'd2, 1'b0, 3'd0, 2'd0, 32'd0, 1'b0, "R5 precharge");
      do_cmd(3'd1, 1'b0, 3'd5, 2'd0, 32'd0, 1'b0, "R8 open destination");
      settle();
      do_rd(1'b0, 2'd3, mdl[0][5][3], "R8 dest write column");
      do_rd(1'b0, 2'd1, mdl[0][5][1], "R8 dest cloned column");

      // R5 closed subarray rejects access, R9 clone on idle
      do_cmd(3'd2, 1'b0, 3'd0, 2'd0, 32'd0, 1'b0, "R5 precharge");
      do_cmd(3'd3, 1'b0, 3'd0, 2'd0, 32'd0, 1'b1, "R5 read after precharge errs");
      do_cmd(3'd4, 1'b0, 3'd0, 2'd0, 32'hDEAD, 1'b1, "R5 write after precharge errs");
      do_cmd(3'd5, 1'b0, 3'd6, 2'd0, 32'd0, 1'b1, "R9 clone while equalized errs");

      // R9 clone while sensing
      do_cmd(3'd1, 1'b1, 3'd1, 2'd0, 32'd0, 1'b0, "R2 activate sub1");
      do_cmd(3'd5, 1'b1, 3'd4, 2'd0, 32'd0, 1'b1, "R9 clone while sensing errs");
      settle();

      // R10 transfer port
      xfer(1'b1, 2'd2, 32'hBEEF, rv, rdat, xe);
      mdl[1][1][2] = 32'hBEEF;
      check(xe === 1'b0, "R10 xfer write accepted", {31'd0, xe}, 32'd0);
      xfer(1'b0, 2'd2, 32'd0, rv, rdat, xe);
      check(rv === 1'b1 && rdat === 32'hBEEF, "R10 xfer read", rdat, 32'hBEEF);
      do_rd(1'b1, 2'd2, 32'hBEEF, "R10 xfer write seen on cmd port");
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = 3'd4; cmd_sub = 1'b1; cmd_col = 2'd0; cmd_wdata = 32'h11;
      xfer_en = 1'b1; xfer_we = 1'b1; xfer_col = 2'd0; xfer_wdata = 32'h99;
      @(posedge clk); #1 cmd_valid = 1'b0; xfer_en = 1'b0;
      @(negedge clk);
      mdl[1][1][0] = 32'h11;
      check(xfer_err === 1'b1, "R10 xfer blocked by write", {31'd0, xfer_err}, 32'd1);
      do_rd(1'b1, 2'd0, 32'h11, "R10 blocked xfer had no effect");
      do_cmd(3'd2, 1'b1, 3'd0, 2'd0, 32'd0, 1'b0, "R5 precharge sub1");
      xfer(1'b0, 2'd0, 32'd0, rv, rdat, xe);
      check(xe === 1'b1 && rv === 1'b0, "R10 xfer with no stable row errs", {30'd0, xe, rv}, 32'd2);
      do_cmd(3'd1, 1'b1, 3'd1, 2'd0, 32'd0, 1'b0, "R4 reopen sub1 row1");
      settle();
      do_rd(1'b1, 2'd2, mdl[1][1][2], "R10 xfer write stored in cells");
      do_cmd(3'd2, 1'b1, 3'd0, 2'd0, 32'd0, 1'b0, "R5 precharge sub1");
      do_cmd(3'd1, 1'b1, 3'd4, 2'd0, 32'd0, 1'b0, "R9 open clone target");
      settle();
      do_rd(1'b1, 2'd0, 32'd0, "R9 rejected clone wrote nothing");

      repeat (4) @(negedge clk);
      check(expq.size() == 0, "R2 all reads returned", expq.size(), 32'd0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule